// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a watchdog timer for a system-on-chip. Software arms it by setting an enable bit and then completing a two-write feed: the byte 0xAA and then the byte 0x55, both written to the feed register. Once armed, a down-counter loaded from a programmable reload register decrements on every clock. If software does not feed again before the counter reaches zero, the watchdog fires a watchdog event. The event is either a one-cycle reset pulse or a persistent interrupt, depending on the reset-select bit that was latched at the last valid feed.

Software cannot clear the enable bit. Only a hardware reset or the watchdog's own event turns the watchdog off. A wrong feed byte is a fault, and so is any other register access between the two feed writes. While the watchdog is armed, a fault fires the same event as an expiry. A debug input suppresses the reset pulse, so a halted processor can be inspected. A sticky timeout flag records that an event happened. That flag survives the watchdog's own event and is cleared only by software or by a hardware reset.

Register map, selected by `busAddr`:
- 0 is the mode register. Bit0 is the enable bit, which can be set and never cleared by a write. Bit1 selects reset on an event. Bit2 is the timeout flag, which is cleared by writing 1 to it. Bit3 is the interrupt flag, which is read-only.
- 1 is the reload register.
- 2 is the feed register. It is write-only and reads as 0.
- 3 is the current count. It is read-only.

Top module: `feed_watchdog`

## Requirements
- R1: After hardware reset, `wdReset` and `wdIrq` are low, the mode register reads 0, and both the reload register and the count read RELOAD_INIT (default 255).
- R2: Writing 1 to mode bit0 sets the enable bit. Writing 0 to mode bit0 leaves it set. Mode bit1 follows each write to the mode register.
- R3: A write of 0xAA to the feed register, followed by a write of 0x55 with no other register access in between, is a valid feed. A valid feed loads the count from the reload register, arms the watchdog if the enable bit is set, and latches the reset-select bit.
- R4: The enable bit and the reset-select bit have no effect until a valid feed: the count holds its value and no event occurs.
- R5: While armed, the count decrements by one per clock. A watchdog event takes effect on the clock edge after the edge at which the count reaches zero, so the event is visible R+1 cycles after a feed that loaded the value R.
- R6: When the latched reset-select bit is 1, an event drives `wdReset` high for exactly one cycle. Every event sets the timeout flag (mode bit2), clears the enable bit, and disarms the watchdog.
- R7: When the latched reset-select bit is 0, an event sets the interrupt flag (mode bit3) and `wdIrq`. Both stay high until a hardware reset.
- R8: While armed, any of the following fires an event on that access's clock edge: a feed-register write of a value other than 0xAA as the first byte, a non-0x55 second byte, or any other register access after the 0xAA.
- R9: While not armed, incorrect or interrupted feed accesses produce no event and leave the flags clear.
- R10: While `dbgMode` is high, an event produces no reset pulse. It still sets the timeout flag and disarms the watchdog.
- R11: The timeout flag stays set after the watchdog's own event and is cleared by writing 1 to mode bit2.
- R12: If the 0x55 write of a feed falls in the cycle in which an armed count is at zero, the expiry takes priority: the event fires and the count is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 2 | Register select |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| dbgMode | input | 1 | Debug mode, suppresses the reset pulse |
| wdReset | output | 1 | One-cycle watchdog reset pulse |
| wdIrq | output | 1 | Sticky watchdog interrupt |

## Verification
The collision of interest is an expiry and a feed completion in the same cycle: the counter sits at zero in the very cycle in which the 0x55 write lands. The bench feeds with a known reload value and waits a computed number of idle cycles. It then places the 0xAA write on the edge where the count reaches zero, so that the 0x55 write coincides with expiry. It judges the outcome by three observations: `wdReset` must pulse on that edge, the count must read 0 rather than the reload value, and the enable bit must read cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_FEED   = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  localparam logic [7:0] FEED_FIRST  = 8'hAA;
  localparam logic [7:0] FEED_SECOND = 8'h55;

  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_RST_BIT = 1;
  localparam int MODE_TOF_BIT = 2;
  localparam int MODE_IRQ_BIT = 3;
  localparam int MODE_W       = 4;

  typedef enum logic {
    FEED_IDLE = 1'b0,
    FEED_HALF = 1'b1
  } feedState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic wrReload;
  } dpStrobe_t;

endpackage

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntValue,
  output logic [DATA_W-1:0] reloadValue,
  output logic              cntZero
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= RELOAD_INIT;
    end else if (strobe.wrReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= RELOAD_INIT;
    end else if (strobe.loadCnt) begin
      cntQ <= reloadQ;
    end else if (strobe.decCnt) begin
      cntQ <= cntQ - ONE;
    end
  end

  assign cntZero     = (cntQ == '0);
  assign cntValue    = cntQ;
  assign reloadValue = reloadQ;

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> (cntQ == $past(reloadQ)));

  // R5
  dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decCnt && !strobe.loadCnt) |=> (cntQ == $past(cntQ) - ONE));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [1:0]        busAddr,
  input  logic [7:0]        wrByte,
  input  logic              cntZero,
  input  logic              dbgMode,
  output dpStrobe_t         strobe,
  output logic [MODE_W-1:0] modeBits,
  output logic              wdReset,
  output logic              wdIrq
);

  feedState_t feedSt, feedNext;
  logic enBit, rstSelBit, tofBit, irqFlag;
  logic armed, rstSelLive, rstPulseQ;
  logic feedGood, feedBad, anyAccess, feedWr;
  logic expire, fault, wdEvent;

  assign anyAccess = busWe | busRe;
  assign feedWr    = busWe && (busAddr == ADDR_FEED);

  always_comb begin
    feedNext = feedSt;
    feedGood = 1'b0;
    feedBad  = 1'b0;
    case (feedSt)
      FEED_IDLE: begin
        if (feedWr) begin
          if (wrByte == FEED_FIRST) feedNext = FEED_HALF;
          else                      feedBad  = 1'b1;
        end
      end
      FEED_HALF: begin
        if (feedWr && (wrByte == FEED_SECOND)) begin
          feedGood = 1'b1;
          feedNext = FEED_IDLE;
        end else if (anyAccess) begin
          feedBad  = 1'b1;
          feedNext = FEED_IDLE;
        end
      end
      default: feedNext = FEED_IDLE;
    endcase
  end

  assign expire  = armed && cntZero;
  assign fault   = armed && feedBad;
  assign wdEvent = expire | fault;

  always_comb begin
    strobe          = '0;
    strobe.loadCnt  = feedGood && !wdEvent;
    strobe.decCnt   = armed && !cntZero;
    strobe.wrReload = busWe && (busAddr == ADDR_RELOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      feedSt     <= FEED_IDLE;
      enBit      <= 1'b0;
      rstSelBit  <= 1'b0;
      tofBit     <= 1'b0;
      irqFlag    <= 1'b0;
      armed      <= 1'b0;
      rstSelLive <= 1'b0;
      rstPulseQ  <= 1'b0;
    end else begin
      feedSt    <= wdEvent ? FEED_IDLE : feedNext;
      rstPulseQ <= 1'b0;
      if (busWe && (busAddr == ADDR_MODE)) begin
        enBit     <= enBit | wrByte[MODE_EN_BIT];
        rstSelBit <= wrByte[MODE_RST_BIT];
        if (wrByte[MODE_TOF_BIT]) tofBit <= 1'b0;
      end
      if (strobe.loadCnt) begin
        armed      <= enBit;
        rstSelLive <= rstSelBit;
      end
      if (wdEvent) begin
        armed     <= 1'b0;
        enBit     <= 1'b0;
        tofBit    <= 1'b1;
        rstPulseQ <= rstSelLive && !dbgMode;
        if (!rstSelLive) irqFlag <= 1'b1;
      end
    end
  end

  assign modeBits = {irqFlag, tofBit, rstSelBit, enBit};
  assign wdReset  = rstPulseQ;
  assign wdIrq    = irqFlag;

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |=> wdIrq);

  // R10
  dbg_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> $past(!dbgMode));

  // R11
  tof_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> tofBit);

  // R4
  arm_only_by_feed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(feedGood));

  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !wdEvent) |=> enBit);

endmodule

// File: rtl/feed_watchdog.sv
module feed_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dbgMode,
  output logic              wdReset,
  output logic              wdIrq
);

  localparam int PAD_W = DATA_W - MODE_W;

  dpStrobe_t         strobe;
  logic [MODE_W-1:0] modeBits;
  logic [DATA_W-1:0] cntValue, reloadValue;
  logic              cntZero;

  wdt_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .wrByte   (busWdata[7:0]),
    .cntZero  (cntZero),
    .dbgMode  (dbgMode),
    .strobe   (strobe),
    .modeBits (modeBits),
    .wdReset  (wdReset),
    .wdIrq    (wdIrq)
  );

  wdt_dp #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (busWdata),
    .cntValue    (cntValue),
    .reloadValue (reloadValue),
    .cntZero     (cntZero)
  );

  always_comb begin
    case (busAddr)
      ADDR_MODE:   busRdata = {{PAD_W{1'b0}}, modeBits};
      ADDR_RELOAD: busRdata = reloadValue;
      ADDR_COUNT:  busRdata = cntValue;
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: tb/feed_watchdog_tb_top.sv
`timescale 1ns/1ps
module feed_watchdog_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0, dbgMode = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wdReset, wdIrq;

  int applied = 0;
  int failed  = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  feed_watchdog dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dbgMode(dbgMode),
    .wdReset(wdReset), .wdIrq(wdIrq)
  );

  typedef struct packed {
    logic [31:0] reload;
    logic        rstSel;
    logic        dbg;
    logic        expPulse;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'd0,  1'b1, 1'b0, 1'b1, 1'b0},
    '{32'd3,  1'b1, 1'b0, 1'b1, 1'b0},
    '{32'd7,  1'b0, 1'b0, 1'b0, 1'b1},
    '{32'd1,  1'b0, 1'b0, 1'b0, 1'b1},
    '{32'd12, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'd20, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'd5,  1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwReset();
    @(negedge clk);
    rstN = 1'b0;
    busWe = 1'b0; busRe = 1'b0; dbgMode = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  initial begin
    #(20ns * 200000);
    failed++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    hwReset();

    // Vector table: expiry timing, reset vs interrupt, debug (R5, R6, R7, R10, R11)
    for (int v = 0; v < NVEC; v++) begin
      int pulseCnt;
      int pulseIdx;
      int irqIdx;
      hwReset();
      wr(2'd1, VECS[v].reload);
      wr(2'd0, {30'd0, VECS[v].rstSel, 1'b1});
      dbgMode = VECS[v].dbg;
      feed();
      pulseCnt = 0; pulseIdx = -1; irqIdx = -1;
      for (int i = 1; i <= int'(VECS[v].reload) + 5; i++) begin
        @(negedge clk);
        if (wdReset) begin pulseCnt++; if (pulseIdx < 0) pulseIdx = i; end
        if (wdIrq && irqIdx < 0) irqIdx = i;
      end
      check("R6 pulse count", pulseCnt, {31'd0, VECS[v].expPulse});
      check("R10 dbg suppression / R6 reset pulse present", {31'd0, pulseCnt > 0}, {31'd0, VECS[v].expPulse});
      if (VECS[v].expPulse) check("R5 pulse timing", pulseIdx, VECS[v].reload + 1);
      check("R7 irq level", {31'd0, wdIrq}, {31'd0, VECS[v].expIrq});
      if (VECS[v].expIrq) check("R5 irq timing", irqIdx, VECS[v].reload + 1);
      rd(2'd0, rv);
      check("R11 tof set after event", {31'd0, rv[2]}, 32'd1);
      check("R6 enable cleared by event", {31'd0, rv[0]}, 32'd0);
      dbgMode = 1'b0;
    end

    // R1 reset state
    hwReset();
    check("R1 wdReset", {31'd0, wdReset}, 32'd0);
    check("R1 wdIrq", {31'd0, wdIrq}, 32'd0);
    rd(2'd0, rv); check("R1 mode", rv, 32'd0);
    rd(2'd3, rv); check("R1 count", rv, 32'd255);
    rd(2'd1, rv); check("R1 reload", rv, 32'd255);

    // R2 enable sticky, R4 no effect before feed
    wr(2'd0, 32'd3);
    rd(2'd0, rv); check("R2 mode set", rv, 32'd3);
    wr(2'd0, 32'd0);
    rd(2'd0, rv); check("R2 enable not clearable", rv, 32'd1);
    repeat (10) @(negedge clk);
    rd(2'd3, rv); check("R4 count holds before feed", rv, 32'd255);
    check("R4 no pulse before feed", {31'd0, wdReset}, 32'd0);

    // R9 bad feed while not armed
    hwReset();
    wr(2'd2, 32'h12);
    wr(2'd2, 32'hAA);
    rd(2'd0, rv); check("R9 flags clear when unarmed", rv, 32'd0);
    check("R9 no irq", {31'd0, wdIrq}, 32'd0);
    check("R9 no reset", {31'd0, wdReset}, 32'd0);

    // R8 wrong first byte while armed, interrupt mode; R7 stickiness
    hwReset();
    wr(2'd1, 32'd100);
    wr(2'd0, 32'd1);
    feed();
    wr(2'd2, 32'h33);
    check("R8 wrong byte fires irq", {31'd0, wdIrq}, 32'd1);
    rd(2'd0, rv); check("R7 mode after irq event", rv, 32'hC);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h4);
    check("R7 irq held until hw reset", {31'd0, wdIrq}, 32'd1);
    hwReset();
    check("R7 irq cleared by hw reset", {31'd0, wdIrq}, 32'd0);

    // R8 interrupted feed, reset mode; R6 single cycle; R11 flag clear
    wr(2'd1, 32'd100);
    wr(2'd0, 32'd3);
    feed();
    wr(2'd2, 32'hAA);
    rd(2'd1, rv);
    check("R8 interrupted feed fires reset", {31'd0, wdReset}, 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, wdReset}, 32'd0);
    rd(2'd0, rv); check("R11 tof survives watchdog event", rv, 32'h6);
    wr(2'd0, 32'h4);
    rd(2'd0, rv); check("R11 tof cleared by write one", rv, 32'd0);

    // R3 refeeds keep alive, R5 decrement
    hwReset();
    wr(2'd1, 32'd10);
    wr(2'd0, 32'd3);
    feed();
    for (int k = 0; k < 3; k++) begin
      repeat (6) @(negedge clk);
      check("R3 no expiry while fed", {31'd0, wdReset}, 32'd0);
      feed();
    end
    rd(2'd3, rv); check("R3 count reloaded", rv, 32'd10);
    rd(2'd3, rv); check("R5 count decrements", rv, 32'd9);

    // R12 feed completion and expiry in same cycle
    hwReset();
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd3);
    feed();
    repeat (3) @(negedge clk);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
    check("R12 expiry wins over feed", {31'd0, wdReset}, 32'd1);
    rd(2'd3, rv); check("R12 count not reloaded", rv, 32'd0);
    rd(2'd0, rv); check("R12 enable cleared", {31'd0, rv[0]}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

endmodule